// File: doc/BRIEF.md
# Windowed Bus-to-System DMA Address Translator

The block converts an address seen on a peripheral (PCI) bus into a system DMA address. It has four programmable windows. Each window holds three 64-bit registers: a window base, a window mask and a translated base. When an address falls inside an enabled window, that window either splices the bus offset directly into its translated base, or runs a scatter-gather lookup. A scatter-gather lookup reads one 64-bit page-table entry from system memory through a request/response port, and the result is built from that entry and the low bus-address bits. An address that no enabled window claims passes through unchanged.

Software programs the windows and a control word through a 64-bit register port. Registers are spaced 64 bytes apart. Two error registers and a cache-invalidate register are kept only as stubs that read as zero. Translation requests are accepted only while the block is idle. Each accepted request ends with a one-cycle done strobe that carries the result.

Top module: `pciwin_xlate`

## Requirements
- R1: After reset, every window base, window mask and translated base register reads 0, the control register reads 64'h0000_0021_0010_0000, and `xl_ready` is 1.
- R2: The register index is `reg_addr >> 6`, so address bits 5:0 are ignored. A read (`reg_valid`=1, `reg_write`=0) returns data on `reg_rdata` with `reg_rvalid`=1 in the following cycle. Index map: window base w at index w (0..3), window mask w at 4+w, translated base w at 8+w, control at 12, error status at 13, error mask at 14, invalidate-all at 15. Each window register reads back the last value written to it.
- R3: The control register (index 12) reads back the last 64-bit value written to it.
- R4: The error status (13), error mask (14) and invalidate-all (15) registers always read 0. Writes to them change no other register.
- R5: Window w hits when its base bit 0 (enable) is 1 and the bus address and the base agree on every bit in 31:20 where mask bit is 0. Bits outside 31:20 take no part in the compare.
- R6: When several windows hit, the lowest-numbered window is used.
- R7: Direct mode (base bit 1 = 0): the result takes bus bits 19:0, plus bus bits in 31:20 where the mask bit is 1. Every other bit comes from the translated base.
- R8: Scatter-gather mode (base bit 1 = 1): the block issues `pt_req_valid` with an entry address built as follows. Bits 2:0 are 0. Bits 9:3 are bus bits 19:13. For b in 20..31, bit b-10 is bus bit b if mask bit b is 1, and translated-base bit b-10 otherwise. Bits 63:22 are translated-base bits 63:22. Valid and address hold until `pt_req_ready`.
- R9: The scatter-gather result is entry bits 51:1 placed at result bits 63:13, with bus bits 12:0 below them.
- R10: With no enabled window hit, the result equals the bus address.
- R11: A direct or miss translation raises `xl_done` with `xl_result` in the cycle after acceptance. A scatter-gather translation raises it in the cycle after `pt_rsp_valid`, and `xl_ready` stays 0 from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte offset from block base |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the read |
| reg_rvalid | output | 1 | Read data valid |
| xl_req | input | 1 | Translate request |
| xl_addr | input | 64 | Bus address to translate |
| xl_ready | output | 1 | Block can accept a request |
| xl_done | output | 1 | One-cycle result strobe |
| xl_result | output | 64 | Translated address |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_ready | input | 1 | Memory accepts the request |
| pt_req_addr | output | 64 | Page-table entry address |
| pt_rsp_valid | input | 1 | Page-table data returned |
| pt_rsp_data | input | 64 | Page-table entry |

## Verification
The hardest situation to reach is a bus address that several enabled windows claim at once, with the lower window in one mode and the higher in the other. Such a case checks priority and mode selection together. The stimulus programs windows with sparse random masks. It then builds each bus address from a chosen window's base under that window's compare mask, so hits are frequent, and overlaps with other windows happen naturally. Directed cases add fully-masked windows that claim every address, and disabled windows whose bases match. The memory side answers after random accept and response delays, which tests that the request is held and that `xl_ready` stays low across the wait.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

  localparam int unsigned XW = 64;

  // compare field of a window: address bits 31:20
  localparam logic [XW-1:0] CMP_FIELD  = 64'h0000_0000_FFF0_0000;
  localparam logic [XW-1:0] LOW_OFS    = 64'h0000_0000_000F_FFFF;
  localparam logic [XW-1:0] SG_IDX_LO  = 64'h0000_0000_000F_E000;
  localparam logic [XW-1:0] PTE_ALIGN  = 64'h0000_0000_0000_03FF;
  localparam logic [XW-1:0] PAGE_OFS   = 64'h0000_0000_0000_1FFF;
  localparam logic [XW-1:0] CTRL_RST   = 64'h0000_0021_0010_0000;

  typedef enum logic [1:0] {XS_IDLE, XS_ISSUE, XS_WAIT} xl_state_e;

  function automatic logic win_hit(input logic [XW-1:0] bus,
                                   input logic [XW-1:0] base,
                                   input logic [XW-1:0] mask);
    logic [XW-1:0] cmp;
    cmp = ~mask & CMP_FIELD;
    return base[0] && ((bus & cmp) == (base & cmp));
  endfunction

  function automatic logic [XW-1:0] direct_map(input logic [XW-1:0] bus,
                                               input logic [XW-1:0] mask,
                                               input logic [XW-1:0] tbase);
    logic [XW-1:0] am;
    am = (mask & CMP_FIELD) | LOW_OFS;
    return (tbase & ~am) | (bus & am);
  endfunction

  function automatic logic [XW-1:0] sg_entry_addr(input logic [XW-1:0] bus,
                                                  input logic [XW-1:0] mask,
                                                  input logic [XW-1:0] tbase);
    logic [XW-1:0] tm;
    logic [XW-1:0] bm;
    tm = ~(((mask & CMP_FIELD) >> 10) | PTE_ALIGN);
    bm = (mask & CMP_FIELD) | SG_IDX_LO;
    return (tbase & tm) | ((bus & bm) >> 10);
  endfunction

  function automatic logic [XW-1:0] sg_result(input logic [XW-1:0] pte,
                                              input logic [XW-1:0] bus);
    return ((pte & ~64'h1) << 12) | (bus & PAGE_OFS);
  endfunction

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
  import pciwin_pkg::*;
#(
  parameter int unsigned NWIN  = 4,
  parameter int unsigned OFS_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_valid,
  input  logic          reg_write,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [XW-1:0] reg_wdata,
  output logic [XW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic [XW-1:0] win_base [NWIN],
  output logic [XW-1:0] win_mask [NWIN],
  output logic [XW-1:0] win_tba  [NWIN]
);

  localparam int unsigned STRIDE_SH = 6;
  localparam int unsigned I_MASK0   = NWIN;
  localparam int unsigned I_TBA0    = 2 * NWIN;
  localparam int unsigned I_CTRL    = 3 * NWIN;
  localparam int unsigned I_ERRST   = I_CTRL + 1;
  localparam int unsigned I_ERRMSK  = I_CTRL + 2;
  localparam int unsigned I_INVAL   = I_CTRL + 3;

  logic [OFS_W-1:0] ridx;
  logic             wr_fire, rd_fire;
  logic [XW-1:0]    ctrl_q;
  logic [XW-1:0]    rd_mux;

  assign ridx    = reg_addr >> STRIDE_SH;
  assign wr_fire = reg_valid && reg_write;
  assign rd_fire = reg_valid && !reg_write;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_base[w] <= '0;
        win_mask[w] <= '0;
        win_tba[w]  <= '0;
      end else if (wr_fire) begin
        if (ridx == OFS_W'(w))          win_base[w] <= reg_wdata;
        if (ridx == OFS_W'(I_MASK0 + w)) win_mask[w] <= reg_wdata;
        if (ridx == OFS_W'(I_TBA0 + w))  win_tba[w]  <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  ctrl_q <= CTRL_RST;
    else if (wr_fire && ridx == OFS_W'(I_CTRL))  ctrl_q <= reg_wdata;
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (ridx == OFS_W'(w))           rd_mux = win_base[w];
      if (ridx == OFS_W'(I_MASK0 + w)) rd_mux = win_mask[w];
      if (ridx == OFS_W'(I_TBA0 + w))  rd_mux = win_tba[w];
    end
    if (ridx == OFS_W'(I_CTRL)) rd_mux = ctrl_q;
    // error status, error mask, invalidate-all and unmapped read zero
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_fire;
      if (rd_fire) reg_rdata <= rd_mux;
    end
  end

  p_read_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> reg_rvalid);

  p_stub_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (ridx == OFS_W'(I_ERRST) || ridx == OFS_W'(I_ERRMSK) ||
                 ridx == OFS_W'(I_INVAL))) |=> (reg_rdata == '0));

  p_ctrl_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && ridx == OFS_W'(I_CTRL)) |=> $stable(ctrl_q));

endmodule

// File: rtl/pciwin_match.sv
module pciwin_match
  import pciwin_pkg::*;
#(
  parameter int unsigned NWIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] bus_addr,
  input  logic [XW-1:0] win_base [NWIN],
  input  logic [XW-1:0] win_mask [NWIN],
  input  logic [XW-1:0] win_tba  [NWIN],
  output logic [NWIN-1:0] hit_vec,
  output logic [NWIN-1:0] sel_vec,
  output logic          any_hit,
  output logic          sel_sg,
  output logic [XW-1:0] direct_addr,
  output logic [XW-1:0] entry_addr
);

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    assign hit_vec[w] = win_hit(bus_addr, win_base[w], win_mask[w]);
  end

  // lowest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    sel_vec = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit_vec[w] && !found) begin
        sel_vec[w] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    logic [XW-1:0] s_base, s_mask, s_tba;
    s_base = '0;
    s_mask = '0;
    s_tba  = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel_vec[w]) begin
        s_base = s_base | win_base[w];
        s_mask = s_mask | win_mask[w];
        s_tba  = s_tba  | win_tba[w];
      end
    end
    any_hit     = |sel_vec;
    sel_sg      = s_base[1];
    direct_addr = direct_map(bus_addr, s_mask, s_tba);
    entry_addr  = sg_entry_addr(bus_addr, s_mask, s_tba);
  end

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  p_sel_within_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec & ~hit_vec) == '0);

  p_hit_selects_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> any_hit);

endmodule

// File: rtl/pciwin_xlate.sv
module pciwin_xlate
  import pciwin_pkg::*;
#(
  parameter int unsigned NWIN  = 4,
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             reg_rvalid,
  input  logic             xl_req,
  input  logic [63:0]      xl_addr,
  output logic             xl_ready,
  output logic             xl_done,
  output logic [63:0]      xl_result,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [63:0]      pt_req_addr,
  input  logic             pt_rsp_valid,
  input  logic [63:0]      pt_rsp_data
);

  logic [XW-1:0]   win_base [NWIN];
  logic [XW-1:0]   win_mask [NWIN];
  logic [XW-1:0]   win_tba  [NWIN];
  logic [NWIN-1:0] hit_vec, sel_vec;
  logic            any_hit, sel_sg;
  logic [XW-1:0]   direct_addr, entry_addr;

  xl_state_e       state_q;
  logic [XW-1:0]   bus_q, ent_q, res_q;
  logic            done_q;

  // named events for the checks
  logic accept, acc_sg, acc_flat, rsp_take;

  pciwin_regs #(.NWIN(NWIN), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .win_base(win_base), .win_mask(win_mask), .win_tba(win_tba)
  );

  pciwin_match #(.NWIN(NWIN)) u_match (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(xl_addr),
    .win_base(win_base), .win_mask(win_mask), .win_tba(win_tba),
    .hit_vec(hit_vec), .sel_vec(sel_vec),
    .any_hit(any_hit), .sel_sg(sel_sg),
    .direct_addr(direct_addr), .entry_addr(entry_addr)
  );

  assign xl_ready = (state_q == XS_IDLE);
  assign accept   = xl_req && xl_ready;
  assign acc_sg   = accept && any_hit && sel_sg;
  assign acc_flat = accept && !(any_hit && sel_sg);
  assign rsp_take = (state_q == XS_WAIT) && pt_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      bus_q   <= '0;
      ent_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        XS_IDLE: begin
          if (acc_sg) begin
            bus_q   <= xl_addr;
            ent_q   <= entry_addr;
            state_q <= XS_ISSUE;
          end else if (acc_flat) begin
            res_q  <= any_hit ? direct_addr : xl_addr;
            done_q <= 1'b1;
          end
        end
        XS_ISSUE: if (pt_req_ready) state_q <= XS_WAIT;
        XS_WAIT: begin
          if (pt_rsp_valid) begin
            res_q   <= sg_result(pt_rsp_data, bus_q);
            done_q  <= 1'b1;
            state_q <= XS_IDLE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign pt_req_valid = (state_q == XS_ISSUE);
  assign pt_req_addr  = ent_q;
  assign xl_done      = done_q;
  assign xl_result    = res_q;

  p_flat_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_flat |=> xl_done);

  p_miss_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> (xl_result == $past(xl_addr)));

  p_sg_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sg |=> (pt_req_valid && !xl_done && !xl_ready));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_addr)));

  p_rsp_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (xl_done && xl_ready));

  p_busy_no_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_ready) |-> !xl_done);

endmodule

// File: tb/sim_pciwin_xlate.sv
module sim_pciwin_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write;
  logic [9:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic        xl_req;
  logic [63:0] xl_addr;
  logic        xl_ready, xl_done;
  logic [63:0] xl_result;
  logic        pt_req_valid, pt_req_ready;
  logic [63:0] pt_req_addr;
  logic        pt_rsp_valid;
  logic [63:0] pt_rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_tba  [4];

  always #4 clk = ~clk;

  pciwin_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .xl_req(xl_req), .xl_addr(xl_addr), .xl_ready(xl_ready),
    .xl_done(xl_done), .xl_result(xl_result),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready),
    .pt_req_addr(pt_req_addr), .pt_rsp_valid(pt_rsp_valid),
    .pt_rsp_data(pt_rsp_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- reference model, bit by bit ----
  function automatic bit f_hit(input logic [63:0] bus, input logic [63:0] base,
                               input logic [63:0] mask);
    if (base[0] !== 1'b1) return 0;
    for (int b = 20; b < 32; b++)
      if (!mask[b] && bus[b] != base[b]) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] f_direct(input logic [63:0] bus,
                                           input logic [63:0] mask,
                                           input logic [63:0] tba);
    logic [63:0] r;
    r = tba;
    r[19:0] = bus[19:0];
    for (int b = 20; b < 32; b++) if (mask[b]) r[b] = bus[b];
    return r;
  endfunction

  function automatic logic [63:0] f_entry(input logic [63:0] bus,
                                          input logic [63:0] mask,
                                          input logic [63:0] tba);
    logic [63:0] r;
    r = tba;
    r[2:0] = 3'b0;
    r[9:3] = bus[19:13];
    for (int b = 20; b < 32; b++) if (mask[b]) r[b-10] = bus[b];
    return r;
  endfunction

  function automatic logic [63:0] f_pte(input logic [63:0] a);
    return {a[31:0] ^ 32'hC3A5_1E77, a[31:0] + 32'h1357_9BDF};
  endfunction

  // ---- register access ----
  task automatic reg_wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 10'(idx << 6); reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(input int idx, input logic [5:0] low, output logic [63:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = 10'(idx << 6) | 10'(low);
    @(negedge clk);
    reg_valid = 0;
    check(reg_rvalid === 1'b1, "R2 rvalid", 64'(reg_rvalid), 64'd1);
    d = reg_rdata;
  endtask

  task automatic prog_win(input int w, input logic [63:0] b,
                          input logic [63:0] m, input logic [63:0] t);
    reg_wr(w, b);     m_base[w] = b;
    reg_wr(4 + w, m); m_mask[w] = m;
    reg_wr(8 + w, t); m_tba[w]  = t;
  endtask

  // ---- one translation with a memory responder ----
  task automatic xlate(input logic [63:0] a);
    int sel = -1;
    logic [63:0] exp_res, exp_ent;
    bit exp_sg;
    bit held = 1;
    for (int w = 0; w < 4; w++)
      if (sel < 0 && f_hit(a, m_base[w], m_mask[w])) sel = w;
    exp_sg = (sel >= 0) && m_base[sel][1];
    if (sel < 0) exp_res = a;
    else if (!exp_sg) exp_res = f_direct(a, m_mask[sel], m_tba[sel]);
    else exp_ent = f_entry(a, m_mask[sel], m_tba[sel]);

    @(negedge clk);
    xl_req = 1; xl_addr = a;
    @(negedge clk);
    xl_req = 0;
    if (!exp_sg) begin
      check(xl_done === 1'b1, "R11 done timing", 64'(xl_done), 64'd1);
      if (sel < 0) check(xl_result === exp_res, "R10 miss", xl_result, exp_res);
      else         check(xl_result === exp_res, "R7 direct (R5 R6 select)", xl_result, exp_res);
    end else begin
      logic [63:0] got_ent;
      check(pt_req_valid === 1'b1 && xl_done === 1'b0, "R8 issue",
            64'(pt_req_valid), 64'd1);
      got_ent = pt_req_addr;
      check(got_ent === exp_ent, "R8 entry addr (R5 R6 select)", got_ent, exp_ent);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        if (pt_req_valid !== 1'b1 || pt_req_addr !== got_ent) held = 0;
      end
      check(held, "R8 hold", 64'(held), 64'd1);
      pt_req_ready = 1;
      @(negedge clk);
      pt_req_ready = 0;
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        if (xl_ready !== 1'b0 || xl_done !== 1'b0) held = 0;
      end
      check(held && !pt_req_valid, "R11 busy while waiting", 64'(xl_ready), 64'd0);
      pt_rsp_valid = 1; pt_rsp_data = f_pte(got_ent);
      @(negedge clk);
      pt_rsp_valid = 0;
      check(xl_done === 1'b1 && xl_ready === 1'b1, "R11 sg done", 64'(xl_done), 64'd1);
      exp_res = {f_pte(got_ent)[51:1], a[12:0]};
      check(xl_result === exp_res, "R9 sg result", xl_result, exp_res);
    end
  endtask

  function automatic logic [63:0] aim(input int w, input logic [63:0] r);
    logic [63:0] a = r;
    for (int b = 20; b < 32; b++) if (!m_mask[w][b]) a[b] = m_base[w][b];
    return a;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20251));
    rst_n = 0; reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
    xl_req = 0; xl_addr = 0; pt_req_ready = 0; pt_rsp_valid = 0; pt_rsp_data = 0;
    for (int w = 0; w < 4; w++) begin m_base[w] = 0; m_mask[w] = 0; m_tba[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check(xl_ready === 1'b1, "R1 ready", 64'(xl_ready), 64'd1);
    for (int i = 0; i < 12; i++) begin
      reg_rd(i, 6'd0, d);
      check(d === 64'd0, "R1 window reg zero", d, 64'd0);
    end
    reg_rd(12, 6'd0, d);
    check(d === 64'h0000_0021_0010_0000, "R1 control reset", d, 64'h0000_0021_0010_0000);

    // R2 readback, low offset bits ignored
    for (int i = 0; i < 12; i++) begin
      logic [63:0] v = {$urandom, $urandom};
      reg_wr(i, v);
      reg_rd(i, 6'($urandom), d);
      check(d === v, "R2 readback", d, v);
    end
    // R3 control
    reg_wr(12, 64'hDEAD_BEEF_0123_4567);
    reg_rd(12, 6'd17, d);
    check(d === 64'hDEAD_BEEF_0123_4567, "R3 control", d, 64'hDEAD_BEEF_0123_4567);
    // R4 stubs
    reg_wr(8, 64'h1111_2222_3333_4444);
    reg_wr(13, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_wr(14, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_wr(15, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 13; i < 16; i++) begin
      reg_rd(i, 6'd0, d);
      check(d === 64'd0, "R4 stub reads zero", d, 64'd0);
    end
    reg_rd(8, 6'd0, d);
    check(d === 64'h1111_2222_3333_4444, "R4 no side effect", d, 64'h1111_2222_3333_4444);
    reg_rd(12, 6'd0, d);
    check(d === 64'hDEAD_BEEF_0123_4567, "R4 no side effect ctrl", d, 64'hDEAD_BEEF_0123_4567);

    // directed: all disabled -> miss (R10), including matching base
    for (int w = 0; w < 4; w++) prog_win(w, 64'h0000_0000_4000_0000, 64'h0, 64'hAAAA_0000_0000_0000);
    xlate(64'h1234_5678_4001_2345);
    // R6 overlap: window 2 direct catch-all, window 3 sg catch-all
    prog_win(3, 64'h3, 64'h0000_0000_FFF0_0000, 64'h0000_0005_5550_0000);
    xlate(64'hFFFF_0000_ABCD_EF01);
    prog_win(2, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7777_6666_5555_4444);
    xlate(64'hFFFF_0000_ABCD_EF01);
    // R5 enabled window, address outside
    prog_win(2, 64'h0000_0000_8000_0001, 64'h0, 64'h0);
    prog_win(3, 64'h0, 64'h0, 64'h0);
    xlate(64'h0000_0000_9000_0000);
    xlate(64'h0000_0000_800F_FFFF);

    // random
    for (int it = 0; it < 300; it++) begin
      if (it % 12 == 0)
        for (int w = 0; w < 4; w++)
          prog_win(w,
                   {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFF0 |
                     64'($urandom_range(0, 9) != 0) | (64'($urandom_range(0, 1)) << 1),
                   {$urandom, $urandom & $urandom & $urandom},
                   {$urandom, $urandom});
      if ($urandom_range(0, 3) == 0) xlate({$urandom, $urandom});
      else xlate(aim($urandom_range(0, 3), {$urandom, $urandom}));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule